// File: doc/BRIEF.md
# Matrix Multiply Index Schedule Generator

This block turns a plain request counter into the operand schedule of an in-register matrix multiply. After a start, every accepted step yields one tuple of three 7-bit register indices. The tuple holds the first source element (A, rows x inner), the second source element (B, inner x cols) and the accumulator element (D, rows x cols) of one multiply-accumulate. The schedule visits output row, then output column, then the shared inner position, with the inner position moving fastest. It has exactly rows x cols x inner tuples. The indices do not depend on the operation applied to them. Integer, Galois-field or AND/OR accumulation all consume the same sequence.

Each operand has three option bits and a base register. The option bits flip the element coordinates and pick row- or column-major storage. The base is added after the remap, wrapping in the 128-entry register space. A reverse flag walks the same schedule from the last tuple back to the first. The size fields are 3 bits each and encode sizes 1 to 8, so shapes such as 5x7, 3x4 and 2x6 need no padding.

Steps come in on a request/ready pair. Tuples leave on a valid/ready pair through one output register. Back-pressure on the output stalls step acceptance, so no tuple is ever dropped or duplicated.

Top module: `mm_idx_sched`

## Requirements
- R1: While and after reset, out_valid, done, busy, step_rdy and cfg_err are low.
- R2: A start pulse latches sizes (field value v means size v+1), option bits, bases and the reverse flag. It clears any pending tuple and positions the schedule at its first tuple. A start while a schedule runs abandons it. If rows x inner, inner x cols or rows x cols exceeds 128, cfg_err is raised and the block stays idle; otherwise cfg_err is low.
- R3: In forward order the inner position k steps fastest, then the column j, then the row i. Exactly rows x cols x inner tuples are produced.
- R4: With option bits zero, idx_a = (base_a + i*inner + k) mod 128, idx_b = (base_b + k*cols + j) mod 128 and idx_d = (base_d + i*cols + j) mod 128. A is addressed at (i,k) with shape rows x inner, B at (k,j) with shape inner x cols, and D at (i,j) with shape rows x cols.
- R5: Option bit 0 (transpose) stores that operand column-major: offset = col*height + row.
- R6: Option bit 1 (mirror) replaces the column coordinate c with width-1-c before the storage mapping.
- R7: Option bit 2 (rotate) turns the operand by 180 degrees: row r becomes height-1-r and column c becomes width-1-c, applied after the mirror.
- R8: With the reverse flag set, the tuples come out in exactly the reverse of the forward order.
- R9: step_rdy = busy and (not out_valid or out_ready). Each step with step_req and step_rdy high at a clock edge loads exactly one tuple. While out_valid is high and out_ready low, the tuple holds stable.
- R10: done is high for one cycle, on the first cycle the last tuple is presented, and busy is low from that cycle on.
- R11: After the last tuple, step requests are ignored: out_valid does not rise again until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch configuration and restart the schedule |
| cfg_rows | input | 3 | Output rows minus one |
| cfg_cols | input | 3 | Output columns minus one |
| cfg_inner | input | 3 | Shared inner size minus one |
| cfg_rev | input | 1 | Walk the schedule in descending order |
| opt_a | input | 3 | A options: bit0 transpose, bit1 mirror, bit2 rotate |
| opt_b | input | 3 | B options, same encoding |
| opt_d | input | 3 | D options, same encoding |
| base_a | input | 7 | Base register of A |
| base_b | input | 7 | Base register of B |
| base_d | input | 7 | Base register of D |
| step_req | input | 1 | Step request |
| step_rdy | output | 1 | Step is accepted at this edge if requested |
| out_valid | output | 1 | Tuple on idx_a/idx_b/idx_d is valid |
| out_ready | input | 1 | Consumer takes the tuple |
| idx_a | output | 7 | First source index |
| idx_b | output | 7 | Second source index |
| idx_d | output | 7 | Accumulator / destination index |
| done | output | 1 | Pulse with the first presentation of the last tuple |
| busy | output | 1 | Schedule has tuples left to issue |
| cfg_err | output | 1 | Last start carried an oversized configuration |

## Verification
Some properties are checked on every cycle. A stalled tuple must stay unchanged. A tuple appears only after a step request. done must coincide with a valid tuple and an idle block. No tuple may appear while the block is idle. The loop positions must stay within the programmed sizes, and each remapped offset must stay inside its operand's element count. Only the directed scenarios can show that the sequence itself is right: the loop order, the transpose, mirror, rotate and wrap arithmetic, the exact reversal, the restart behaviour and the single done pulse. Those are compared tuple by tuple against a model built from the requirements.

// File: rtl/mm_sched_pkg.sv
package mm_sched_pkg;
  // Per-operand coordinate transform, bit order matches the option ports.
  typedef struct packed {
    logic rot;  // bit 2: 180-degree turn
    logic mir;  // bit 1: column flip
    logic trn;  // bit 0: column-major storage
  } xform_t;

  localparam int NOPS = 3;  // A, B, D
endpackage

// File: rtl/mm_loop_ctr.sv
module mm_loop_ctr #(
  parameter int DIM_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             rev_in,
  input  logic [DIM_W-1:0] max_r_in,
  input  logic [DIM_W-1:0] max_c_in,
  input  logic [DIM_W-1:0] max_k_in,
  input  logic             adv,
  output logic [DIM_W-1:0] pos_r,
  output logic [DIM_W-1:0] pos_c,
  output logic [DIM_W-1:0] pos_k,
  output logic [DIM_W-1:0] lim_r,
  output logic [DIM_W-1:0] lim_c,
  output logic [DIM_W-1:0] lim_k,
  output logic             last
);
  logic rev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_r <= '0; pos_c <= '0; pos_k <= '0;
      lim_r <= '0; lim_c <= '0; lim_k <= '0;
      rev_q <= 1'b0;
    end else if (load) begin
      lim_r <= max_r_in; lim_c <= max_c_in; lim_k <= max_k_in;
      rev_q <= rev_in;
      if (rev_in) begin
        pos_r <= max_r_in; pos_c <= max_c_in; pos_k <= max_k_in;
      end else begin
        pos_r <= '0; pos_c <= '0; pos_k <= '0;
      end
    end else if (adv) begin
      if (!rev_q) begin
        if (pos_k == lim_k) begin
          pos_k <= '0;
          if (pos_c == lim_c) begin
            pos_c <= '0;
            pos_r <= pos_r + 1'b1;
          end else begin
            pos_c <= pos_c + 1'b1;
          end
        end else begin
          pos_k <= pos_k + 1'b1;
        end
      end else begin
        if (pos_k == '0) begin
          pos_k <= lim_k;
          if (pos_c == '0) begin
            pos_c <= lim_c;
            pos_r <= pos_r - 1'b1;
          end else begin
            pos_c <= pos_c - 1'b1;
          end
        end else begin
          pos_k <= pos_k - 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (rev_q) last = (pos_r == '0) && (pos_c == '0) && (pos_k == '0);
    else       last = (pos_r == lim_r) && (pos_c == lim_c) && (pos_k == lim_k);
  end

  // R3
  ctr_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_r <= lim_r) && (pos_c <= lim_c) && (pos_k <= lim_k));
endmodule

// File: rtl/mm_remap.sv
module mm_remap
  import mm_sched_pkg::*;
#(
  parameter int DIM_W = 3,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] row,
  input  logic [DIM_W-1:0] col,
  input  logic [DIM_W-1:0] hmax,
  input  logic [DIM_W-1:0] wmax,
  input  xform_t           opt,
  input  logic [IDX_W-1:0] base,
  output logic [IDX_W-1:0] idx
);
  localparam int OW = 2 * DIM_W + 2;

  logic [DIM_W-1:0] rr, cc;
  logic [OW-1:0]    h, w, off;

  always_comb begin
    rr  = opt.rot ? (hmax - row) : row;
    // mirror and rotate each flip the column; both together cancel
    cc  = (opt.rot ^ opt.mir) ? (wmax - col) : col;
    h   = OW'(hmax) + OW'(1);
    w   = OW'(wmax) + OW'(1);
    off = opt.trn ? (OW'(cc) * h + OW'(rr)) : (OW'(rr) * w + OW'(cc));
    idx = base + IDX_W'(off);
  end

  // R4
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off < h * w);
endmodule

// File: rtl/mm_idx_sched.sv
module mm_idx_sched
  import mm_sched_pkg::*;
#(
  parameter int DIM_W = 3,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] cfg_rows,
  input  logic [DIM_W-1:0] cfg_cols,
  input  logic [DIM_W-1:0] cfg_inner,
  input  logic             cfg_rev,
  input  logic [2:0]       opt_a,
  input  logic [2:0]       opt_b,
  input  logic [2:0]       opt_d,
  input  logic [IDX_W-1:0] base_a,
  input  logic [IDX_W-1:0] base_b,
  input  logic [IDX_W-1:0] base_d,
  input  logic             step_req,
  output logic             step_rdy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] idx_a,
  output logic [IDX_W-1:0] idx_b,
  output logic [IDX_W-1:0] idx_d,
  output logic             done,
  output logic             busy,
  output logic             cfg_err
);
  localparam int REG_SPACE = 1 << IDX_W;

  logic busy_q, vld_q, done_q, err_q;
  logic bad_cfg, accept, load, last;
  logic [DIM_W-1:0] pr, pc, pk, lr, lc, lk;
  xform_t           opt_q [NOPS];
  logic [IDX_W-1:0] base_q[NOPS];
  logic [IDX_W-1:0] idx_q [NOPS];
  logic [DIM_W-1:0] rv[NOPS], cv[NOPS], hv[NOPS], wv[NOPS];
  logic [IDX_W-1:0] iv[NOPS];

  always_comb begin
    int sz_a, sz_b, sz_d;
    sz_a    = (int'(cfg_rows)  + 1) * (int'(cfg_inner) + 1);
    sz_b    = (int'(cfg_inner) + 1) * (int'(cfg_cols)  + 1);
    sz_d    = (int'(cfg_rows)  + 1) * (int'(cfg_cols)  + 1);
    bad_cfg = (sz_a > REG_SPACE) || (sz_b > REG_SPACE) || (sz_d > REG_SPACE);
  end

  assign load     = start && !bad_cfg;
  assign step_rdy = busy_q && (!vld_q || out_ready);
  assign accept   = step_req && step_rdy && !start;

  mm_loop_ctr #(.DIM_W(DIM_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .rev_in(cfg_rev),
    .max_r_in(cfg_rows), .max_c_in(cfg_cols), .max_k_in(cfg_inner),
    .adv(accept && !last),
    .pos_r(pr), .pos_c(pc), .pos_k(pk),
    .lim_r(lr), .lim_c(lc), .lim_k(lk), .last(last)
  );

  // Operand coordinate and shape selection: A(i,k) RxK, B(k,j) KxC, D(i,j) RxC
  always_comb begin
    rv[0] = pr; cv[0] = pk; hv[0] = lr; wv[0] = lk;
    rv[1] = pk; cv[1] = pc; hv[1] = lk; wv[1] = lc;
    rv[2] = pr; cv[2] = pc; hv[2] = lr; wv[2] = lc;
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_map
    mm_remap #(.DIM_W(DIM_W), .IDX_W(IDX_W)) u_map (
      .clk(clk), .rst_n(rst_n),
      .row(rv[g]), .col(cv[g]), .hmax(hv[g]), .wmax(wv[g]),
      .opt(opt_q[g]), .base(base_q[g]), .idx(iv[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; vld_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      for (int n = 0; n < NOPS; n++) begin
        opt_q[n] <= '0; base_q[n] <= '0; idx_q[n] <= '0;
      end
    end else if (start) begin
      err_q     <= bad_cfg;
      busy_q    <= !bad_cfg;
      vld_q     <= 1'b0;
      done_q    <= 1'b0;
      opt_q[0]  <= xform_t'(opt_a);
      opt_q[1]  <= xform_t'(opt_b);
      opt_q[2]  <= xform_t'(opt_d);
      base_q[0] <= base_a;
      base_q[1] <= base_b;
      base_q[2] <= base_d;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        for (int n = 0; n < NOPS; n++) idx_q[n] <= iv[n];
        vld_q  <= 1'b1;
        done_q <= last;
        if (last) busy_q <= 1'b0;
      end else if (vld_q && out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign done      = done_q;
  assign busy      = busy_q;
  assign cfg_err   = err_q;
  assign idx_a     = idx_q[0];
  assign idx_b     = idx_q[1];
  assign idx_d     = idx_q[2];

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready && !start) |=>
      (vld_q && $stable(idx_a) && $stable(idx_b) && $stable(idx_d)));

  // R9
  valid_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(step_req));

  // R10
  done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (vld_q && !busy_q));

  // R11
  idle_no_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> !$rose(vld_q));
endmodule

// File: tb/mm_idx_sched_tb.sv
module mm_idx_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] cfg_rows = '0, cfg_cols = '0, cfg_inner = '0;
  logic       cfg_rev = 1'b0;
  logic [2:0] opt_a = '0, opt_b = '0, opt_d = '0;
  logic [6:0] base_a = '0, base_b = '0, base_d = '0;
  logic       step_req = 1'b0;
  logic       out_ready = 1'b0;
  logic       step_rdy, out_valid, done, busy, cfg_err;
  logic [6:0] idx_a, idx_b, idx_d;

  int checks = 0;
  int errors = 0;
  int exp_t[0:1023];

  always #4 clk = ~clk;  // 125 MHz

  mm_idx_sched dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_inner(cfg_inner),
    .cfg_rev(cfg_rev), .opt_a(opt_a), .opt_b(opt_b), .opt_d(opt_d),
    .base_a(base_a), .base_b(base_b), .base_d(base_d),
    .step_req(step_req), .step_rdy(step_rdy),
    .out_valid(out_valid), .out_ready(out_ready),
    .idx_a(idx_a), .idx_b(idx_b), .idx_d(idx_d),
    .done(done), .busy(busy), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Offset inside an operand from the option rules (R5, R6, R7, R4)
  function automatic int xoff(int r, int c, int h, int w, logic [2:0] o);
    if (o[1]) c = w - 1 - c;
    if (o[2]) begin r = h - 1 - r; c = w - 1 - c; end
    return o[0] ? (c * h + r) : (r * w + c);
  endfunction

  task automatic do_start(input int r, input int c, input int k, input logic rev,
                          input logic [2:0] oa, input logic [2:0] ob, input logic [2:0] od,
                          input int ba, input int bb, input int bd);
    @(negedge clk);
    cfg_rows = 3'(r - 1); cfg_cols = 3'(c - 1); cfg_inner = 3'(k - 1);
    cfg_rev = rev; opt_a = oa; opt_b = ob; opt_d = od;
    base_a = 7'(ba); base_b = 7'(bb); base_d = 7'(bd);
    step_req = 1'b0; out_ready = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input int r, input int c, input int k, input logic rev,
                     input logic [2:0] oa, input logic [2:0] ob, input logic [2:0] od,
                     input int ba, input int bb, input int bd,
                     input bit stall, input string tag);
    int n_all, got, dones, cyc;
    n_all = r * c * k;
    got = 0;
    for (int i = 0; i < r; i++)
      for (int j = 0; j < c; j++)
        for (int q = 0; q < k; q++) begin
          int ea, eb, ed, pos;
          ea = (ba + xoff(i, q, r, k, oa)) % 128;
          eb = (bb + xoff(q, j, k, c, ob)) % 128;
          ed = (bd + xoff(i, j, r, c, od)) % 128;
          pos = rev ? (n_all - 1 - got) : got;
          exp_t[pos] = (ea << 14) | (eb << 7) | ed;
          got++;
        end
    do_start(r, c, k, rev, oa, ob, od, ba, bb, bd);
    chk(busy === 1'b1 && out_valid === 1'b0 && cfg_err === 1'b0,
        {tag, " R2 start"}, {busy, out_valid, cfg_err}, 3'b100);
    got = 0; dones = 0; cyc = 0;
    while (got < n_all && cyc < 5000) begin
      step_req  = 1'b1;
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (done === 1'b1) begin
        dones++;
        chk(got == n_all - 1 && out_valid === 1'b1 && busy === 1'b0,
            {tag, " R10 done on last"}, got, n_all - 1);
      end
      if (out_valid === 1'b1 && out_ready) begin
        chk({idx_a, idx_b, idx_d} == 21'(exp_t[got]),
            {tag, rev ? " R8 tuple" : " R3 tuple"}, {idx_a, idx_b, idx_d}, exp_t[got]);
        got++;
      end
      cyc++;
      @(negedge clk);
    end
    chk(got == n_all, {tag, " R3 count"}, got, n_all);
    chk(dones == 1, {tag, " R10 single pulse"}, dones, 1);
    // R11: further step requests change nothing
    for (int t = 0; t < 4; t++) begin
      step_req = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0 && busy === 1'b0 && done === 1'b0,
          {tag, " R11 ignored step"}, {out_valid, busy, done}, 0);
    end
    step_req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({out_valid, done, busy, step_rdy, cfg_err} === 5'b0, "R1 reset",
        {out_valid, done, busy, step_rdy, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({out_valid, done, busy, step_rdy, cfg_err} === 5'b0, "R1 after reset",
        {out_valid, done, busy, step_rdy, cfg_err}, 0);
  endtask

  task automatic t_plain();   // R4 row-major, R3 order, 5x7 output
    run(5, 7, 3, 1'b0, 3'b000, 3'b000, 3'b000, 0, 20, 50, 1'b0, "plain");
  endtask

  task automatic t_options(); // R5 R6 R7 with base wrap on D
    run(3, 4, 2, 1'b0, 3'b001, 3'b010, 3'b100, 10, 40, 120, 1'b0, "opts");
    run(2, 6, 4, 1'b0, 3'b110, 3'b011, 3'b101, 100, 64, 7, 1'b0, "mixed");
  endtask

  task automatic t_reverse(); // R8
    run(2, 6, 4, 1'b1, 3'b011, 3'b110, 3'b101, 0, 64, 32, 1'b0, "rev");
  endtask

  task automatic t_stall();   // R9 back-pressure, full 8x8 output
    run(8, 8, 2, 1'b0, 3'b000, 3'b001, 3'b010, 0, 16, 64, 1'b1, "stall");
  endtask

  task automatic t_hold();    // R9 tuple held while not ready
    logic [20:0] first;
    do_start(3, 4, 2, 1'b0, 3'b000, 3'b000, 3'b000, 5, 6, 7);
    out_ready = 1'b0; step_req = 1'b1;
    @(negedge clk);
    first = {idx_a, idx_b, idx_d};
    chk(out_valid === 1'b1 && first == {7'd5, 7'd6, 7'd7}, "R9 first tuple", first,
        {7'd5, 7'd6, 7'd7});
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b1 && step_rdy === 1'b0 && {idx_a, idx_b, idx_d} == first,
        "R9 hold", {idx_a, idx_b, idx_d}, first);
    out_ready = 1'b1;
    @(negedge clk);
    chk({idx_a, idx_b, idx_d} == {7'd6, 7'd10, 7'd7}, "R9 next after release",
        {idx_a, idx_b, idx_d}, {7'd6, 7'd10, 7'd7});
    step_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_single();  // R10 1x1x1: first tuple is last
    run(1, 1, 1, 1'b0, 3'b111, 3'b111, 3'b111, 127, 3, 9, 1'b0, "single");
  endtask

  task automatic t_restart(); // R2 start mid-run restarts
    do_start(4, 4, 4, 1'b0, 3'b000, 3'b000, 3'b000, 1, 2, 3);
    step_req = 1'b1; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    step_req = 1'b0;
    run(3, 2, 5, 1'b1, 3'b001, 3'b000, 3'b010, 30, 60, 90, 1'b0, "restart R2");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_plain();
        t_options();
        t_reverse();
        t_stall();
        t_hold();
        t_single();
        t_restart();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule